// File: doc/BRIEF.md
# Interrupt Acceptance Gate with Status Word

The block keeps the 16-bit processor status word and decides, once per instruction, whether an interrupt is taken. The status word holds three fields: a privilege flag in bit 15, where 1 means user mode; the running priority in bits [10:8]; and the condition flags in bits [2:0]. Up to eight device lines each raise a request when both the device's ready flag and its enable flag are set. Every line has a fixed 3-bit priority that is chosen at build time.

When the datapath signals that the store phase has ended, the gate compares the requests with the running priority. It then either lets execution continue or posts an offer to the sequencer that saves PC and status. The offer carries three items: an 8-bit vector equal to 0x80 plus the winning line index, the status word to be saved, and the status word the handler starts with. The offer is a valid/ready stream. It holds every field stable until `take_ready` is seen high, and the status word switches to the handler's value on that handshake.

The datapath also writes new condition flags, and a return sequence restores a whole status word. After a restore, a one-cycle flag reports whether the restored word selects the user stack.

Top module: `irq_gate`

## Requirements
- R1: After reset the status word is 0x0002, meaning supervisor, priority 0 and flag Z. `take_valid` and `ret_user` are both 0.
- R2: A line requests only when its `dev_ready` and `dev_ie` bits are both 1. With either bit at 0, the line never produces an offer.
- R3: A request qualifies only if the line's priority is strictly greater than status bits [10:8]. An equal or lower priority produces no offer.
- R4: Requests are sampled only in a cycle where `boundary` is 1. `take_valid` rises on the clock edge after such a cycle and never without one.
- R5: Among qualifying lines, the one with the highest priority wins, and the lowest index wins a tie. `take_vec` = 0x80 + index. With the default build, the priorities of lines 0 to 7 are 1, 4, 4, 7, 2, 5, 3, 6.
- R6: While `take_valid` is 1 and `take_ready` is 0, the vector and both status outputs stay stable, and new `boundary` cycles are ignored.
- R7: `take_saved_psr` is the status word in effect in the sampling cycle, including a same-cycle flag write or restore. `take_new_psr` equals it with bit 15 cleared and bits [10:8] set to the winner's priority.
- R8: On the cycle after `take_valid` and `take_ready` are both 1, `take_valid` is 0 and the status word equals the offered `take_new_psr`.
- R9: When no offer is pending, `cc_valid` writes `cc_in` into status bits [2:0] on the next edge and leaves the other bits unchanged. While an offer is pending, `cc_valid` is ignored.
- R10: When no offer is pending, `ret_valid` loads `ret_psr` into the status word and wins over `cc_valid`. On the next cycle, `ret_user` is 1 for one cycle if `ret_psr[15]` is 1. While an offer is pending, `ret_valid` is ignored. A restore in a sampling cycle is compared using the restored priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_ready | input | 8 | Per-line device ready flags |
| dev_ie | input | 8 | Per-line interrupt enable flags |
| boundary | input | 1 | End of store phase; the sampling point |
| cc_valid | input | 1 | Write condition flags this cycle |
| cc_in | input | 3 | New condition flags (N,Z,P) |
| ret_valid | input | 1 | Restore the whole status word this cycle |
| ret_psr | input | 16 | Status word being restored |
| take_valid | output | 1 | Interrupt offer pending |
| take_ready | input | 1 | Sequencer accepts the offer |
| take_vec | output | 8 | Vector of the winning line |
| take_saved_psr | output | 16 | Status word to push |
| take_new_psr | output | 16 | Status word for the handler |
| psr | output | 16 | Current status word |
| ret_user | output | 1 | One-cycle flag: restored word selects the user stack |

## Verification
Two functions can fall in the same cycle. The first is the sampling of requests at `boundary`. The second is a change of the status word through a flag write or a restore, both of which the sampling must see. The bench drives `cc_valid` together with `boundary` and checks that the saved status word carries the new flags. It also drives a restore that raises the priority to 7 together with `boundary`, and checks that no offer appears. A third case drives a flag write, a restore and a higher-priority boundary while an offer is stalled; the bench checks that none of them changes the offer or the status word.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int PSR_W    = 16;
  localparam int PL_W     = 3;
  localparam int CC_W     = 3;
  localparam int PRIV_BIT = 15;
  localparam int PL_LSB   = 8;

  // replace the condition flag field
  function automatic logic [PSR_W-1:0] psr_set_cc(input logic [PSR_W-1:0] p,
                                                   input logic [CC_W-1:0] cc);
    logic [PSR_W-1:0] r;
    r = p;
    r[CC_W-1:0] = cc;
    return r;
  endfunction

  // handler entry: supervisor, priority raised to accepted level
  function automatic logic [PSR_W-1:0] psr_enter(input logic [PSR_W-1:0] p,
                                                 input logic [PL_W-1:0] pl);
    logic [PSR_W-1:0] r;
    r = p;
    r[PRIV_BIT] = 1'b0;
    r[PL_LSB +: PL_W] = pl;
    return r;
  endfunction
endpackage

// File: rtl/irq_req_qual.sv
module irq_req_qual
  import irq_gate_pkg::*;
#(
  parameter int N = 8,
  parameter logic [N*PL_W-1:0] PRIO = '0
) (
  input  logic [N-1:0]    ready,
  input  logic [N-1:0]    ie,
  input  logic [PL_W-1:0] cur_pl,
  output logic [N-1:0]    qual
);
  // R2 / R3: request = ready AND enable, qualified by strict priority
  for (genvar g = 0; g < N; g++) begin : g_line
    assign qual[g] = ready[g] & ie[g] & (PRIO[g*PL_W +: PL_W] > cur_pl);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_gate_pkg::*;
#(
  parameter int N = 8,
  parameter logic [N*PL_W-1:0] PRIO = '0,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    qual,
  output logic            any,
  output logic [IW-1:0]   idx,
  output logic [PL_W-1:0] prio
);
  // R5: highest priority wins; strict compare keeps the lowest index on ties
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    prio = '0;
    for (int i = 0; i < N; i++) begin
      if (qual[i] && (!any || (PRIO[i*PL_W +: PL_W] > prio))) begin
        any  = 1'b1;
        idx  = IW'(i);
        prio = PRIO[i*PL_W +: PL_W];
      end
    end
  end
endmodule

// File: rtl/irq_psr_reg.sv
module irq_psr_reg
  import irq_gate_pkg::*;
#(
  parameter logic [PSR_W-1:0] RST_PSR = 16'h0002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend,
  input  logic             cc_valid,
  input  logic [CC_W-1:0]  cc_in,
  input  logic             ret_valid,
  input  logic [PSR_W-1:0] ret_psr,
  input  logic             accept,
  input  logic [PSR_W-1:0] accept_psr,
  output logic [PSR_W-1:0] psr_q,
  output logic [PSR_W-1:0] psr_eff,
  output logic             ret_user
);
  // R9 / R10: updates apply only with no offer pending; restore wins over flags
  always_comb begin
    psr_eff = psr_q;
    if (!pend) begin
      if (ret_valid)     psr_eff = ret_psr;
      else if (cc_valid) psr_eff = psr_set_cc(psr_q, cc_in);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psr_q    <= RST_PSR;
      ret_user <= 1'b0;
    end else begin
      psr_q    <= accept ? accept_psr : psr_eff;   // R8
      ret_user <= ret_valid & ~pend & ret_psr[PRIV_BIT];
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int N = 8,
  parameter logic [N*PL_W-1:0] LINE_PRIO =
    {3'd6, 3'd3, 3'd5, 3'd2, 3'd7, 3'd4, 3'd4, 3'd1},
  parameter logic [7:0] VEC_BASE = 8'h80,
  parameter logic [PSR_W-1:0] RST_PSR = 16'h0002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     dev_ready,
  input  logic [N-1:0]     dev_ie,
  input  logic             boundary,
  input  logic             cc_valid,
  input  logic [CC_W-1:0]  cc_in,
  input  logic             ret_valid,
  input  logic [PSR_W-1:0] ret_psr,
  output logic             take_valid,
  input  logic             take_ready,
  output logic [7:0]       take_vec,
  output logic [PSR_W-1:0] take_saved_psr,
  output logic [PSR_W-1:0] take_new_psr,
  output logic [PSR_W-1:0] psr,
  output logic             ret_user
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     qual;
  logic             win_any;
  logic [IW-1:0]    win_idx;
  logic [PL_W-1:0]  win_prio;
  logic [PSR_W-1:0] psr_eff;
  logic             accept;

  assign accept = take_valid & take_ready;

  irq_psr_reg #(.RST_PSR(RST_PSR)) u_psr (
    .clk(clk), .rst_n(rst_n), .pend(take_valid),
    .cc_valid(cc_valid), .cc_in(cc_in),
    .ret_valid(ret_valid), .ret_psr(ret_psr),
    .accept(accept), .accept_psr(take_new_psr),
    .psr_q(psr), .psr_eff(psr_eff), .ret_user(ret_user)
  );

  irq_req_qual #(.N(N), .PRIO(LINE_PRIO)) u_qual (
    .ready(dev_ready), .ie(dev_ie),
    .cur_pl(psr_eff[PL_LSB +: PL_W]), .qual(qual)
  );

  irq_pick #(.N(N), .PRIO(LINE_PRIO)) u_pick (
    .qual(qual), .any(win_any), .idx(win_idx), .prio(win_prio)
  );

  // R4 / R6 / R7: offer captured at the boundary, held until handshake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_valid     <= 1'b0;
      take_vec       <= '0;
      take_saved_psr <= '0;
      take_new_psr   <= '0;
    end else if (take_valid) begin
      if (take_ready) take_valid <= 1'b0;
    end else if (boundary && win_any) begin
      take_valid     <= 1'b1;
      take_vec       <= VEC_BASE + 8'(win_idx);
      take_saved_psr <= psr_eff;
      take_new_psr   <= psr_enter(psr_eff, win_prio);
    end
  end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int N = 8,
  parameter logic [7:0] VEC_BASE = 8'h80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        take_valid,
  input logic        take_ready,
  input logic [7:0]  take_vec,
  input logic [15:0] take_saved_psr,
  input logic [15:0] take_new_psr,
  input logic [15:0] psr
);
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && !take_ready |=> take_valid && $stable(take_vec) && $stable(take_saved_psr) && $stable(take_new_psr)); // R6
  AST_PSR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && !take_ready |=> $stable(psr)); // R9
  AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && take_ready |=> !take_valid && psr == $past(take_new_psr)); // R8
  AST_STRICT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> take_new_psr[10:8] > take_saved_psr[10:8]); // R3
  AST_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> !take_new_psr[15]); // R7
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (int'(take_vec) >= int'(VEC_BASE)) && (int'(take_vec) < int'(VEC_BASE) + N)); // R5
  AST_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !take_valid && !boundary |=> !take_valid); // R4
endmodule

bind irq_gate irq_gate_chk #(.N(N), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary),
  .take_valid(take_valid), .take_ready(take_ready), .take_vec(take_vec),
  .take_saved_psr(take_saved_psr), .take_new_psr(take_new_psr), .psr(psr)
);

// File: tb/irq_gate_bench.sv
`timescale 1ns/1ps
module irq_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  dev_ready = '0, dev_ie = '0;
  logic        boundary = 1'b0, cc_valid = 1'b0, ret_valid = 1'b0, take_ready = 1'b0;
  logic [2:0]  cc_in = '0;
  logic [15:0] ret_psr = '0;
  logic        take_valid, ret_user;
  logic [7:0]  take_vec;
  logic [15:0] take_saved_psr, take_new_psr, psr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_gate u_irq_gate (
    .clk(clk), .rst_n(rst_n), .dev_ready(dev_ready), .dev_ie(dev_ie),
    .boundary(boundary), .cc_valid(cc_valid), .cc_in(cc_in),
    .ret_valid(ret_valid), .ret_psr(ret_psr),
    .take_valid(take_valid), .take_ready(take_ready), .take_vec(take_vec),
    .take_saved_psr(take_saved_psr), .take_new_psr(take_new_psr),
    .psr(psr), .ret_user(ret_user)
  );

  // {ready, ie, running pl, expect offer, expect vec, expect winner prio}
  localparam logic [30:0] TBL [10] = '{
    {8'h01, 8'h01, 3'd0, 1'b1, 8'h80, 3'd1},
    {8'hFF, 8'h00, 3'd0, 1'b0, 8'h00, 3'd0},
    {8'h06, 8'h06, 3'd3, 1'b1, 8'h81, 3'd4},
    {8'hFF, 8'hFF, 3'd0, 1'b1, 8'h83, 3'd7},
    {8'hFF, 8'hF7, 3'd0, 1'b1, 8'h87, 3'd6},
    {8'h08, 8'h08, 3'd7, 1'b0, 8'h00, 3'd0},
    {8'h20, 8'h20, 3'd5, 1'b0, 8'h00, 3'd0},
    {8'h20, 8'h20, 3'd4, 1'b1, 8'h85, 3'd5},
    {8'hF0, 8'h0F, 3'd0, 1'b0, 8'h00, 3'd0},
    {8'h14, 8'h14, 3'd3, 1'b1, 8'h82, 3'd4}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic restore(input logic [15:0] p);
    ret_valid = 1'b1; ret_psr = p;
    step();
    ret_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] sv;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 reset psr", psr, 16'h0002);
    chk("R1 reset take_valid", take_valid, 0);
    chk("R1 reset ret_user", ret_user, 0);

    // table walk: R2 R3 R5 R7 R8
    for (int k = 0; k < 10; k++) begin
      logic [15:0] p;
      p = {1'b1, 4'b0, TBL[k][14:12], 5'b0, 3'b001};
      restore(p);
      dev_ready = TBL[k][30:23]; dev_ie = TBL[k][22:15]; boundary = 1'b1;
      step();
      boundary = 1'b0; dev_ready = '0; dev_ie = '0;
      chk($sformatf("R5 R2 R3 entry %0d valid", k), take_valid, TBL[k][11]);
      if (TBL[k][11]) begin
        chk($sformatf("R5 entry %0d vec", k), take_vec, TBL[k][10:3]);
        chk($sformatf("R7 entry %0d saved", k), take_saved_psr, p);
        sv = {1'b0, 4'b0, TBL[k][2:0], 5'b0, 3'b001};
        chk($sformatf("R7 entry %0d new", k), take_new_psr, sv);
        take_ready = 1'b1;
        step();
        take_ready = 1'b0;
        chk($sformatf("R8 entry %0d psr", k), psr, sv);
        chk($sformatf("R8 entry %0d drop", k), take_valid, 0);
      end
    end

    // R10 restore with user flag, pulse of one cycle
    ret_valid = 1'b1; ret_psr = 16'h8001;
    step();
    ret_valid = 1'b0;
    chk("R10 ret_user pulse", ret_user, 1);
    chk("R10 psr loaded", psr, 16'h8001);
    step();
    chk("R10 ret_user drops", ret_user, 0);
    restore(16'h0001);
    chk("R10 supervisor restore no flag", ret_user, 0);

    // R4 requests without boundary
    dev_ready = 8'hFF; dev_ie = 8'hFF;
    step(); step(); step();
    chk("R4 no boundary no offer", take_valid, 0);
    dev_ready = '0; dev_ie = '0;

    // R6 R9 R10: stalled offer ignores boundary, flags and restore
    dev_ready = 8'h01; dev_ie = 8'h01; boundary = 1'b1;
    step();
    chk("R6 offer up", take_vec, 8'h80);
    dev_ready = 8'hFF; dev_ie = 8'hFF;
    cc_valid = 1'b1; cc_in = 3'b100; ret_valid = 1'b1; ret_psr = 16'h8702;
    step();
    boundary = 1'b0; cc_valid = 1'b0; ret_valid = 1'b0; dev_ready = '0; dev_ie = '0;
    chk("R6 vec held", take_vec, 8'h80);
    chk("R6 saved held", take_saved_psr, 16'h0001);
    chk("R9 flags ignored while pending", psr, 16'h0001);
    chk("R10 restore ignored while pending", ret_user, 0);
    take_ready = 1'b1;
    step();
    take_ready = 1'b0;
    chk("R8 accept psr", psr, 16'h0101);

    // R9 flag write
    cc_valid = 1'b1; cc_in = 3'b100;
    step();
    cc_valid = 1'b0;
    chk("R9 flags written", psr, 16'h0104);

    // R7 flag write in the sampling cycle
    restore(16'h8001);
    cc_valid = 1'b1; cc_in = 3'b010; boundary = 1'b1; dev_ready = 8'h01; dev_ie = 8'h01;
    step();
    cc_valid = 1'b0; boundary = 1'b0; dev_ready = '0; dev_ie = '0;
    chk("R7 same-cycle flags saved", take_saved_psr, 16'h8002);
    chk("R7 same-cycle new psr", take_new_psr, 16'h0102);
    take_ready = 1'b1;
    step();
    take_ready = 1'b0;

    // R10 restore in the sampling cycle raises the bar to 7
    ret_valid = 1'b1; ret_psr = 16'h8701; boundary = 1'b1; dev_ready = 8'hFF; dev_ie = 8'hFF;
    step();
    ret_valid = 1'b0; boundary = 1'b0; dev_ready = '0; dev_ie = '0;
    chk("R10 same-cycle restore blocks", take_valid, 0);
    chk("R10 same-cycle restore psr", psr, 16'h8701);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule